// File: doc/BRIEF.md
# Multi-Mode Serial Bit Clock Generator

This block sets the bit timing for a serial transmitter and receiver pair. It offers four clocking schemes. Two are asynchronous: a normal one with 16 base ticks per bit and a double-speed one with 8 base ticks per bit. The other two are synchronous: in master mode the block drives the transfer-clock pin itself, and in slave mode it follows a transfer clock supplied from outside. A programmable down-counter sets the base tick rate, and every mode derives its timing from that base tick.

Two strobes come out of the block. `tx_tick_o` tells the transmitter when to move to its next bit. `rx_tick_o` tells the receiver when to sample. In asynchronous modes `rx_tick_o` is the oversampling tick. In synchronous modes the two strobes follow the edges of the transfer clock: the receiver samples on the rising edge and the transmitter shifts on the falling edge. The transfer-clock pin is driven or sampled only in synchronous mode. Whether the block is master or slave follows the direction bit of that pin.

Top module: `ser_clk_gen`

## Requirements
- R1: While `rst_ni` is low, with `sync_mode_i`=0, all outputs (`tx_tick_o`, `rx_tick_o`, `xclk_o`, `xclk_oe_o`, `xclk_rise_o`, `xclk_fall_o`) are 0.
- R2: In asynchronous mode (`sync_mode_i`=0), `rx_tick_o` pulses for one cycle every `divisor_i`+1 system clocks, including when `divisor_i`=0 (a pulse every cycle).
- R3: In normal asynchronous mode (`dbl_speed_i`=0), `tx_tick_o` pulses once every 16 base ticks, that is every 16×(`divisor_i`+1) clocks, and only in a cycle where `rx_tick_o` is also high.
- R4: In double-speed asynchronous mode (`dbl_speed_i`=1), `tx_tick_o` pulses every 8×(`divisor_i`+1) clocks, and `rx_tick_o` keeps the base period `divisor_i`+1.
- R5: In asynchronous mode, `xclk_oe_o`, `xclk_o`, `xclk_rise_o` and `xclk_fall_o` stay 0 whatever `xclk_i` does.
- R6: In master mode (`sync_mode_i`=1, `xclk_dir_i`=1), `xclk_oe_o` is 1 and `xclk_o` changes level every `divisor_i`+1 clocks, which gives a transfer-clock period of 2×(`divisor_i`+1).
- R7: In master mode, `rx_tick_o` is high in the cycle just before `xclk_o` rises and `tx_tick_o` in the cycle just before it falls. The two are never high together, so each pulses once per transfer-clock period.
- R8: `dbl_speed_i` has no effect in synchronous mode: with `dbl_speed_i`=1 the master `tx_tick_o` period stays 2×(`divisor_i`+1).
- R9: In slave mode (`sync_mode_i`=1, `xclk_dir_i`=0), `xclk_oe_o` and `xclk_o` are 0. `xclk_i` passes through a two-flop synchronizer. A level change driven before clock edge k appears as a one-cycle `xclk_rise_o` (for 0→1) or `xclk_fall_o` (for 1→0) in the cycle after edge k+1. `rx_tick_o` equals `xclk_rise_o` and `tx_tick_o` equals `xclk_fall_o`.
- R10: A one-cycle `divisor_wr_i` restarts the base counter from `divisor_i`. No base tick appears in the cycle after the write, and the next `rx_tick_o` comes `divisor_i`+1 cycles after that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_mode_i | input | 1 | 0 asynchronous, 1 synchronous |
| dbl_speed_i | input | 1 | Double-speed select, used in asynchronous mode only |
| xclk_dir_i | input | 1 | Transfer-clock pin direction: 1 output (master), 0 input (slave) |
| divisor_i | input | 12 | Base tick divisor; period is value+1 clocks |
| divisor_wr_i | input | 1 | One-cycle strobe that restarts the counter from `divisor_i` |
| xclk_i | input | 1 | Transfer-clock pin input |
| tx_tick_o | output | 1 | Transmit bit strobe |
| rx_tick_o | output | 1 | Receive sample strobe |
| xclk_o | output | 1 | Transfer-clock pin output value |
| xclk_oe_o | output | 1 | Transfer-clock pin output enable |
| xclk_rise_o | output | 1 | Synchronized rising-edge strobe of `xclk_i` |
| xclk_fall_o | output | 1 | Synchronized falling-edge strobe of `xclk_i` |

## Verification
The bench measures the distance from one tick to the next for a divisor of zero and for nonzero divisors. An off-by-one reload in the counter would give a period of D or D+2 in place of D+1, and a wrong bit-width in the prescaler would give the same 8× or 16× spacing in both asynchronous modes. In master mode, setting the double-speed bit must leave the transfer-clock period unchanged. A design that let that bit leak into synchronous mode would halve the period. For the slave synchronizer, the bench checks the exact cycle in which the edge strobe appears. A missing or extra synchronizer stage moves the strobe by one cycle, and an edge detector that is not single-cycle holds it high. The bench also toggles the pin in asynchronous mode and issues a divisor write in the middle of a count, which catches a pin that is sampled when it should not be and a write that only takes effect at the next natural reload.

// File: rtl/ser_clk_pkg.sv
`timescale 1ns/1ps
package ser_clk_pkg;

  typedef enum logic [1:0] {
    MODE_ASYNC_NORM  = 2'd0,
    MODE_ASYNC_DBL   = 2'd1,
    MODE_SYNC_MASTER = 2'd2,
    MODE_SYNC_SLAVE  = 2'd3
  } clk_mode_e;

  function automatic clk_mode_e decode_mode(input logic sync_mode,
                                            input logic dbl_speed,
                                            input logic xclk_dir);
    if (!sync_mode) return dbl_speed ? MODE_ASYNC_DBL : MODE_ASYNC_NORM;
    return xclk_dir ? MODE_SYNC_MASTER : MODE_SYNC_SLAVE;
  endfunction

endpackage

// File: rtl/ser_clk_baud_cnt.sv
`timescale 1ns/1ps
module ser_clk_baud_cnt #(
  parameter int DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             reload_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;
  logic             tick_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= at_zero && !reload_i;
      if (reload_i || at_zero) cnt_q <= div_i;
      else                     cnt_q <= cnt_q - 1'b1;
    end
  end

  assign tick_o = tick_q;

endmodule

// File: rtl/ser_clk_prescale.sv
`timescale 1ns/1ps
module ser_clk_prescale #(
  parameter int OVS_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic half_i,
  input  logic tick_i,
  output logic wrap_o
);

  logic [OVS_W-1:0] pre_q;
  logic             full_last;
  logic             half_last;

  assign full_last = (pre_q == '1);
  assign half_last = (pre_q[OVS_W-2:0] == '1);
  assign wrap_o    = tick_i && (half_i ? half_last : full_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (clr_i)   pre_q <= '0;
    else if (tick_i)  pre_q <= pre_q + 1'b1;
  end

endmodule

// File: rtl/ser_clk_xclk_sync.sv
`timescale 1ns/1ps
module ser_clk_xclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic xclk_i,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], xclk_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o =  sync_q[STAGES-1] && !prev_q;
  assign fall_o = !sync_q[STAGES-1] &&  prev_q;

endmodule

// File: rtl/ser_clk_gen.sv
`timescale 1ns/1ps
module ser_clk_gen
  import ser_clk_pkg::*;
#(
  parameter int DIV_W       = 12,
  parameter int OVS_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_mode_i,
  input  logic             dbl_speed_i,
  input  logic             xclk_dir_i,
  input  logic [DIV_W-1:0] divisor_i,
  input  logic             divisor_wr_i,
  input  logic             xclk_i,
  output logic             tx_tick_o,
  output logic             rx_tick_o,
  output logic             xclk_o,
  output logic             xclk_oe_o,
  output logic             xclk_rise_o,
  output logic             xclk_fall_o
);

  clk_mode_e mode;
  logic      base_tick;
  logic      ovs_wrap;
  logic      ext_rise, ext_fall;
  logic      mclk_q;
  logic      is_master;

  assign mode      = decode_mode(sync_mode_i, dbl_speed_i, xclk_dir_i);
  assign is_master = (mode == MODE_SYNC_MASTER);

  ser_clk_baud_cnt #(.DIV_W(DIV_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .div_i    (divisor_i),
    .reload_i (divisor_wr_i),
    .tick_o   (base_tick)
  );

  ser_clk_prescale #(.OVS_W(OVS_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (sync_mode_i || divisor_wr_i),
    .half_i (mode == MODE_ASYNC_DBL),
    .tick_i (base_tick),
    .wrap_o (ovs_wrap)
  );

  ser_clk_xclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .xclk_i (xclk_i),
    .rise_o (ext_rise),
    .fall_o (ext_fall)
  );

  // master clock level; idles low outside master mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         mclk_q <= 1'b0;
    else if (!is_master) mclk_q <= 1'b0;
    else if (base_tick)  mclk_q <= !mclk_q;
  end

  always_comb begin
    tx_tick_o   = 1'b0;
    rx_tick_o   = 1'b0;
    xclk_o      = 1'b0;
    xclk_oe_o   = 1'b0;
    xclk_rise_o = 1'b0;
    xclk_fall_o = 1'b0;
    unique case (mode)
      MODE_ASYNC_NORM, MODE_ASYNC_DBL: begin
        rx_tick_o = base_tick;
        tx_tick_o = ovs_wrap;
      end
      MODE_SYNC_MASTER: begin
        xclk_oe_o = 1'b1;
        xclk_o    = mclk_q;
        rx_tick_o = base_tick && !mclk_q;
        tx_tick_o = base_tick &&  mclk_q;
      end
      MODE_SYNC_SLAVE: begin
        xclk_rise_o = ext_rise;
        xclk_fall_o = ext_fall;
        rx_tick_o   = ext_rise;
        tx_tick_o   = ext_fall;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ser_clk_gen_chk.sv
`timescale 1ns/1ps
module ser_clk_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sync_mode_i,
  input logic xclk_dir_i,
  input logic divisor_wr_i,
  input logic xclk_i,
  input logic tx_tick_o,
  input logic rx_tick_o,
  input logic xclk_o,
  input logic xclk_oe_o,
  input logic xclk_rise_o,
  input logic xclk_fall_o
);

  logic [2:0] cyc_q;
  logic       master, slave;

  assign master = sync_mode_i &&  xclk_dir_i;
  assign slave  = sync_mode_i && !xclk_dir_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cyc_q <= '0;
    else if (cyc_q != 3'd7)  cyc_q <= cyc_q + 1'b1;
  end

  a_r5_async_pin_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_mode_i |-> (!xclk_oe_o && !xclk_o && !xclk_rise_o && !xclk_fall_o));

  a_r3_tx_on_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_mode_i && tx_tick_o) |-> rx_tick_o);

  a_r7_master_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master |-> !(tx_tick_o && rx_tick_o));

  a_r7_master_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master && rx_tick_o) |=> (!master || xclk_o));

  a_r7_master_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master && tx_tick_o) |=> !xclk_o);

  a_r9_slave_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 3'd4 && xclk_rise_o) |-> ($past(xclk_i, 2) && !$past(xclk_i, 3)));

  a_r9_slave_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slave |-> (rx_tick_o == xclk_rise_o && tx_tick_o == xclk_fall_o && !xclk_oe_o));

  a_r10_wr_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (divisor_wr_i && !sync_mode_i) |=> (sync_mode_i || !rx_tick_o));

endmodule

bind ser_clk_gen ser_clk_gen_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sync_mode_i  (sync_mode_i),
  .xclk_dir_i   (xclk_dir_i),
  .divisor_wr_i (divisor_wr_i),
  .xclk_i       (xclk_i),
  .tx_tick_o    (tx_tick_o),
  .rx_tick_o    (rx_tick_o),
  .xclk_o       (xclk_o),
  .xclk_oe_o    (xclk_oe_o),
  .xclk_rise_o  (xclk_rise_o),
  .xclk_fall_o  (xclk_fall_o)
);

// File: tb/sim_ser_clk_gen.sv
`timescale 1ns/1ps
module sim_ser_clk_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_mode = 1'b0, dbl_speed = 1'b0, xclk_dir = 1'b0;
  logic [11:0] divisor = 12'd0;
  logic        divisor_wr = 1'b0;
  logic        xclk_in = 1'b0;
  logic        tx_tick, rx_tick, xclk_out, xclk_oe, xclk_rise, xclk_fall;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  ser_clk_gen u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .sync_mode_i  (sync_mode),
    .dbl_speed_i  (dbl_speed),
    .xclk_dir_i   (xclk_dir),
    .divisor_i    (divisor),
    .divisor_wr_i (divisor_wr),
    .xclk_i       (xclk_in),
    .tx_tick_o    (tx_tick),
    .rx_tick_o    (rx_tick),
    .xclk_o       (xclk_out),
    .xclk_oe_o    (xclk_oe),
    .xclk_rise_o  (xclk_rise),
    .xclk_fall_o  (xclk_fall)
  );

  task automatic check(input string req, input int act, input int exp);
    n_total++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input logic s, input logic d, input logic dbl, input int div);
    @(negedge clk);
    sync_mode = s; xclk_dir = d; dbl_speed = dbl;
    divisor = 12'(div); divisor_wr = 1'b1;
    @(negedge clk);
    divisor_wr = 1'b0;
  endtask

  // cycles from one tick to the next
  task automatic meas(input bit use_tx, output int n);
    int guard = 0;
    n = 0;
    while (!(use_tx ? tx_tick : rx_tick) && guard < 5000) begin
      @(negedge clk); guard++;
    end
    do begin @(negedge clk); n++; end
    while (!(use_tx ? tx_tick : rx_tick) && n < 5000);
  endtask

  task automatic t_reset;
    #1;
    check("R1 tx_tick in reset", tx_tick, 0);
    check("R1 rx_tick in reset", rx_tick, 0);
    check("R1 pin out/oe in reset", {xclk_out, xclk_oe}, 0);
    check("R1 strobes in reset", {xclk_rise, xclk_fall}, 0);
  endtask

  task automatic t_async_norm;
    int n;
    cfg(1'b0, 1'b0, 1'b0, 2);
    meas(1'b0, n); check("R2 rx period D=2", n, 3);
    meas(1'b0, n); check("R2 rx period D=2 again", n, 3);
    meas(1'b1, n); meas(1'b1, n); check("R3 tx period 16x D=2", n, 48);
    cfg(1'b0, 1'b0, 1'b0, 0);
    meas(1'b0, n); check("R2 rx period D=0", n, 1);
    meas(1'b1, n); meas(1'b1, n); check("R3 tx period 16x D=0", n, 16);
  endtask

  task automatic t_async_dbl;
    int n;
    cfg(1'b0, 1'b0, 1'b1, 4);
    meas(1'b0, n); check("R4 rx period dbl D=4", n, 5);
    meas(1'b1, n); meas(1'b1, n); check("R4 tx period 8x D=4", n, 40);
  endtask

  task automatic t_async_pin_ignored;
    int bad = 0;
    cfg(1'b0, 1'b1, 1'b0, 1);
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (xclk_oe || xclk_out || xclk_rise || xclk_fall) bad++;
      xclk_in = (i % 3) == 0;
    end
    @(negedge clk);
    if (xclk_oe || xclk_out || xclk_rise || xclk_fall) bad++;
    xclk_in = 1'b0;
    check("R5 pin idle in async", bad, 0);
  endtask

  task automatic t_master(input logic dbl);
    int n;
    logic lvl;
    int miss = 0;
    cfg(1'b1, 1'b1, dbl, 3);
    @(negedge clk);
    if (dbl == 1'b0) begin
      check("R6 oe in master", xclk_oe, 1);
      lvl = xclk_out;
      while (xclk_out == lvl) @(negedge clk);
      lvl = xclk_out; n = 0;
      while (xclk_out == lvl && n < 100) begin @(negedge clk); n++; end
      check("R6 master half period D=3", n, 4);
      for (int i = 0; i < 40; i++) begin
        if (rx_tick) begin
          if (xclk_out != 1'b0) miss++;
          @(negedge clk);
          if (xclk_out != 1'b1) miss++;
        end else @(negedge clk);
      end
      check("R7 rx tick before rise", miss, 0);
      meas(1'b1, n); meas(1'b1, n); check("R7 tx period master D=3", n, 8);
    end else begin
      meas(1'b1, n); meas(1'b1, n); check("R8 dbl ignored master tx period", n, 8);
      meas(1'b0, n); check("R8 dbl ignored master rx period", n, 8);
    end
  endtask

  task automatic t_slave;
    cfg(1'b1, 1'b0, 1'b0, 0);
    repeat (4) @(negedge clk);
    check("R9 oe low in slave", {xclk_oe, xclk_out}, 0);
    xclk_in = 1'b1;
    @(negedge clk); check("R9 no rise after 1 edge", xclk_rise, 0);
    @(negedge clk); check("R9 rise after 2 edges", {xclk_rise, rx_tick, tx_tick}, 3'b110);
    @(negedge clk); check("R9 rise single cycle", xclk_rise, 0);
    repeat (3) @(negedge clk);
    xclk_in = 1'b0;
    @(negedge clk); check("R9 no fall after 1 edge", xclk_fall, 0);
    @(negedge clk); check("R9 fall after 2 edges", {xclk_fall, tx_tick, rx_tick}, 3'b110);
    @(negedge clk); check("R9 fall single cycle", xclk_fall, 0);
  endtask

  task automatic t_div_write;
    int n;
    cfg(1'b0, 1'b0, 1'b0, 40);
    repeat (13) @(negedge clk);
    divisor = 12'd6; divisor_wr = 1'b1;
    @(negedge clk);
    divisor_wr = 1'b0;
    check("R10 no tick right after write", rx_tick, 0);
    n = 0;
    while (!rx_tick && n < 200) begin @(negedge clk); n++; end
    check("R10 restart distance D=6", n, 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_async_norm();
    t_async_dbl();
    t_async_pin_ignored();
    t_master(1'b0);
    t_master(1'b1);
    t_slave();
    t_div_write();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL watchdog R1..R10 run actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

endmodule